// File: doc/BRIEF.md
# CAN Bitwise Arbitration Unit

This unit runs the arbitration phase of a CAN transmitter. It holds a small table of pending transmit messages, continuously picks the one whose arbitration field would win on the bus, and, when a start of frame is signalled, shifts that field out one bit per strobe. At every strobe it compares the level read back from the receive line with the level it is driving.

Logic 0 is dominant and logic 1 is recessive. If the node drives recessive but reads dominant, another node has a higher-priority message. The unit pulses a lost flag, reports the bit index of the loss, and drives recessive for the rest of the frame. If it drives dominant but reads recessive, that is a bit error and not a loss. If the whole field goes out with no mismatch, the unit pulses a won flag and reports which table entry won. Bit timing, stuffing, CRC and the data phase belong to neighbouring logic. The `bit_tick` strobe marks each sample point, and `frame_end` returns the unit to idle.

Top module: `can_arb_unit`

## Requirements
- R1: After reset, `tx_bit` is 1 (recessive), `arb_busy`, `arb_won`, `arb_lost` and `bit_err` are 0.
- R2: Each entry's priority key is its arbitration field left-justified in 32 bits and padded with 1s. `sel_idx` names the valid entry with the numerically lowest key, and the lowest index wins on equal keys. `sel_valid` is 1 exactly when some entry is valid. When `sel_valid` is 1, `tx_valid[sel_idx]` is 1.
- R3: On `sof` while idle with `sel_valid` = 1, the selected entry is latched and `arb_busy` rises. The entry is sent MSB first, with bit 0 on `tx_bit` from the next cycle and each later bit after each `bit_tick`. A standard entry (`tx_ext`=0) sends 12 bits: `tx_id[10:0]` from bit 10 down, then RTR. An extended entry sends 32 bits: `tx_id[28:18]`, a 1, a 1, `tx_id[17:0]`, then RTR.
- R4: At a `bit_tick` where `tx_bit`=1 and `rx_bit`=0, `arb_lost` pulses for one cycle. At the same time `lost_pos` takes the index of that bit, counted from 0 at the first bit. `tx_bit` then stays 1 until `frame_end`.
- R5: If every bit of the field reads back equal to what was sent, `arb_won` pulses for one cycle after the tick of the last bit. `won_idx` gives the latched entry, and `tx_bit` is 1 afterwards.
- R6: At a `bit_tick` where `tx_bit`=0 and `rx_bit`=1, `bit_err` pulses for one cycle and `arb_lost` does not. `tx_bit` then stays 1 until `frame_end`. At most one of `arb_won`, `arb_lost` and `bit_err` is high in any cycle.
- R7: `sof` while idle with no valid entry starts no transmission. `tx_bit` stays 1, `arb_busy` stays 0 and no flag pulses.
- R8: `frame_end` returns the unit to idle from any state, with `tx_bit`=1 and `arb_busy`=0. `sof` outside idle is ignored.
- R9: In a cycle with none of `bit_tick`, `sof` and `frame_end`, `tx_bit` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Sample-point strobe, one cycle per bus bit |
| sof | input | 1 | Start of frame seen on the bus |
| frame_end | input | 1 | Frame over, return to idle |
| rx_bit | input | 1 | Bus level read back from the receive line |
| tx_valid | input | N | Pending flag per table entry |
| tx_id | input | 29*N | Identifier per entry, entry k in bits [29k+28:29k] |
| tx_ext | input | N | Extended-format flag per entry |
| tx_rtr | input | N | RTR bit per entry |
| sel_idx | output | IDX_W | Entry currently chosen for arbitration |
| sel_valid | output | 1 | Some entry is pending |
| tx_bit | output | 1 | Level driven onto the transmit line |
| arb_busy | output | 1 | Arbitration field being sent |
| arb_won | output | 1 | One-cycle pulse: arbitration won |
| arb_lost | output | 1 | One-cycle pulse: arbitration lost |
| bit_err | output | 1 | One-cycle pulse: dominant sent, recessive read |
| lost_pos | output | 6 | Bit index of the last loss |
| won_idx | output | IDX_W | Entry latched for the current frame |

## Verification
The hardest case to reach is a loss or bit error late in a 32-bit extended field, because the random competitor key must match the sent bits for many positions. The stimulus draws identifiers from a small shared pool part of the time, so competitor and sender share long prefixes. It also places injected bit errors at random positions. Equal-key ties in the selector come from the same pool. `sof` pulses are additionally thrown in during arbitration to show they are ignored.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
    localparam int ID_W  = 29;
    localparam int KEY_W = 32;
    localparam int POS_W = 6;

    typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_WON, ST_LISTEN} arb_state_e;

    // Arbitration field, left-justified, recessive padding.
    function automatic logic [KEY_W-1:0] arb_key(input logic [ID_W-1:0] id,
                                                  input logic ext, input logic rtr);
        if (ext)
            return {id[28:18], 1'b1, 1'b1, id[17:0], rtr};
        return {id[10:0], rtr, 20'hFFFFF};
    endfunction

    function automatic logic [POS_W-1:0] arb_last(input logic ext);
        return ext ? POS_W'(31) : POS_W'(11);
    endfunction
endpackage

// File: rtl/can_arb_keygen.sv
module can_arb_keygen
    import can_arb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N*ID_W-1:0]  ids,
    input  logic [N-1:0]       ext,
    input  logic [N-1:0]       rtr,
    output logic [KEY_W-1:0]   keys [N]
);
    for (genvar k = 0; k < N; k++) begin : g_key
        assign keys[k] = arb_key(ids[k*ID_W +: ID_W], ext[k], rtr[k]);
    end
endmodule

// File: rtl/can_arb_select.sv
module can_arb_select
    import can_arb_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]      valid,
    input  logic [KEY_W-1:0]  keys [N],
    output logic [IDX_W-1:0]  best_idx,
    output logic [KEY_W-1:0]  best_key,
    output logic              best_ok
);
    always_comb begin
        best_idx = '0;
        best_key = '1;
        best_ok  = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (valid[k] && (!best_ok || keys[k] < best_key)) begin
                best_idx = IDX_W'(k);
                best_key = keys[k];
                best_ok  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/can_arb_unit.sv
module can_arb_unit
    import can_arb_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                sof,
    input  logic                frame_end,
    input  logic                rx_bit,
    input  logic [N-1:0]        tx_valid,
    input  logic [N*ID_W-1:0]   tx_id,
    input  logic [N-1:0]        tx_ext,
    input  logic [N-1:0]        tx_rtr,
    output logic [IDX_W-1:0]    sel_idx,
    output logic                sel_valid,
    output logic                tx_bit,
    output logic                arb_busy,
    output logic                arb_won,
    output logic                arb_lost,
    output logic                bit_err,
    output logic [POS_W-1:0]    lost_pos,
    output logic [IDX_W-1:0]    won_idx
);
    typedef struct packed {
        arb_state_e        st;
        logic [KEY_W-1:0]  key;
        logic [POS_W-1:0]  idx;
        logic [POS_W-1:0]  last;
        logic              tx;
        logic              won;
        logic              lost;
        logic              berr;
        logic [POS_W-1:0]  lpos;
        logic [IDX_W-1:0]  widx;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [KEY_W-1:0] keys [N];
    logic [KEY_W-1:0] sel_key;

    can_arb_keygen #(.N(N)) u_keygen (
        .ids (tx_id),
        .ext (tx_ext),
        .rtr (tx_rtr),
        .keys(keys)
    );

    can_arb_select #(.N(N)) u_select (
        .valid   (tx_valid),
        .keys    (keys),
        .best_idx(sel_idx),
        .best_key(sel_key),
        .best_ok (sel_valid)
    );

    always_comb begin
        r_d      = r_q;
        r_d.won  = 1'b0;
        r_d.lost = 1'b0;
        r_d.berr = 1'b0;
        if (frame_end) begin
            r_d.st = ST_IDLE;
            r_d.tx = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (sof) begin
                        if (sel_valid) begin
                            r_d.st   = ST_ARB;
                            r_d.key  = sel_key;
                            r_d.tx   = sel_key[KEY_W-1];
                            r_d.idx  = '0;
                            r_d.last = arb_last(tx_ext[sel_idx]);
                            r_d.widx = sel_idx;
                        end else begin
                            r_d.st = ST_LISTEN;
                        end
                    end
                end
                ST_ARB: begin
                    if (bit_tick) begin
                        if (r_q.key[KEY_W-1] && !rx_bit) begin
                            r_d.st   = ST_LISTEN;
                            r_d.tx   = 1'b1;
                            r_d.lost = 1'b1;
                            r_d.lpos = r_q.idx;
                        end else if (!r_q.key[KEY_W-1] && rx_bit) begin
                            r_d.st   = ST_LISTEN;
                            r_d.tx   = 1'b1;
                            r_d.berr = 1'b1;
                        end else if (r_q.idx == r_q.last) begin
                            r_d.st  = ST_WON;
                            r_d.tx  = 1'b1;
                            r_d.won = 1'b1;
                        end else begin
                            r_d.key = {r_q.key[KEY_W-2:0], 1'b1};
                            r_d.tx  = r_q.key[KEY_W-2];
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                default: begin
                    r_d.tx = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.key  <= '1;
            r_q.tx   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_bit   = r_q.tx;
    assign arb_busy = (r_q.st == ST_ARB);
    assign arb_won  = r_q.won;
    assign arb_lost = r_q.lost;
    assign bit_err  = r_q.berr;
    assign lost_pos = r_q.lpos;
    assign won_idx  = r_q.widx;
endmodule

// File: rtl/can_arb_checker.sv
module can_arb_checker #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             sof,
    input logic             frame_end,
    input logic             rx_bit,
    input logic [N-1:0]     tx_valid,
    input logic [IDX_W-1:0] sel_idx,
    input logic             sel_valid,
    input logic             tx_bit,
    input logic             arb_won,
    input logic             arb_lost,
    input logic             bit_err
);
    assert_sel_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> tx_valid[sel_idx]);

    assert_lost_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> ($past(tx_bit) && !$past(rx_bit) && $past(bit_tick)));

    assert_lost_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> tx_bit);

    assert_won_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arb_won |-> ($past(tx_bit) == $past(rx_bit)));

    assert_berr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> (!$past(tx_bit) && $past(rx_bit)));

    assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_won, arb_lost, bit_err}));

    assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> tx_bit);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !sof && !frame_end) |=> $stable(tx_bit));
endmodule

bind can_arb_unit can_arb_checker #(.N(N)) u_can_arb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .sof      (sof),
    .frame_end(frame_end),
    .rx_bit   (rx_bit),
    .tx_valid (tx_valid),
    .sel_idx  (sel_idx),
    .sel_valid(sel_valid),
    .tx_bit   (tx_bit),
    .arb_won  (arb_won),
    .arb_lost (arb_lost),
    .bit_err  (bit_err)
);

// File: tb/tb_can_arb_unit.sv
`timescale 1ns/1ps
module tb_can_arb_unit;
    localparam int N = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, sof = 0, frame_end = 0, rx_bit = 1;
    logic [N-1:0] tx_valid = '0, tx_ext = '0, tx_rtr = '0;
    logic [N*29-1:0] tx_id = '0;
    logic [IW-1:0] sel_idx, won_idx;
    logic sel_valid, tx_bit, arb_busy, arb_won, arb_lost, bit_err;
    logic [5:0] lost_pos;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    can_arb_unit #(.N(N)) dut (.*);

    function automatic logic [31:0] key_of(input logic [28:0] id, input logic e, input logic r);
        if (e) return {id[28:18], 2'b11, id[17:0], r};
        return {id[10:0], r, 20'hFFFFF};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        bit_tick = 0; sof = 0; frame_end = 0;
    endtask

    function automatic logic [28:0] rand_id(input bit pool);
        if (pool) return 29'($urandom_range(0, 3)) | 29'h0AA_5500;
        return 29'($urandom);
    endfunction

    task automatic fill_table(input bit none);
        for (int k = 0; k < N; k++) begin
            bit pool = ($urandom_range(0, 9) < 4);
            tx_valid[k] = none ? 1'b0 : 1'($urandom_range(0, 3) != 0);
            tx_ext[k]   = 1'($urandom);
            tx_rtr[k]   = 1'($urandom);
            tx_id[k*29 +: 29] = rand_id(pool);
        end
    endtask

    task automatic run_frame(input bit none);
        int best; logic [31:0] bkey, okey, mk; int last; int errpos; bit done;
        fill_table(none);
        #1;
        best = -1; bkey = '1;
        for (int k = 0; k < N; k++) begin
            mk = key_of(tx_id[k*29 +: 29], tx_ext[k], tx_rtr[k]);
            if (tx_valid[k] && (best < 0 || mk < bkey)) begin best = k; bkey = mk; end
        end
        chk(sel_valid == (best >= 0), "R2 sel_valid", sel_valid, best >= 0);
        if (best >= 0) chk(sel_idx == IW'(best), "R2 sel_idx", sel_idx, best);
        sof = 1;
        step();
        if (best < 0) begin
            for (int i = 0; i < 6; i++) begin
                chk(tx_bit && !arb_busy && !arb_won && !arb_lost && !bit_err,
                    "R7 no valid", tx_bit, 1);
                bit_tick = 1; rx_bit = 1'($urandom);
                step();
            end
        end else begin
            last = tx_ext[best] ? 31 : 11;
            chk(arb_busy == 1, "R3 busy", arb_busy, 1);
            okey = ($urandom_range(0, 2) == 0) ? '1 :
                   key_of(rand_id($urandom_range(0, 1) == 0), 1'($urandom), 1'($urandom));
            errpos = ($urandom_range(0, 4) == 0) ? $urandom_range(0, last) : -1;
            done = 0;
            for (int i = 0; i <= last && !done; i++) begin
                logic mb, bus;
                mb = bkey[31-i];
                for (int g = $urandom_range(0, 2); g > 0; g--) begin
                    if ($urandom_range(0, 3) == 0) sof = 1;
                    step();
                    chk(tx_bit == mb, "R9 hold / R8 sof ignored", tx_bit, mb);
                end
                chk(tx_bit == mb, "R3 serial bit", tx_bit, mb);
                bus = mb & okey[31-i];
                if (i == errpos && !mb) bus = 1;
                rx_bit = bus; bit_tick = 1;
                step();
                if (mb && !bus) begin
                    chk(arb_lost && !bit_err && !arb_won, "R4 lost pulse", arb_lost, 1);
                    chk(lost_pos == 6'(i), "R4 lost_pos", lost_pos, i);
                    done = 1;
                end else if (!mb && bus) begin
                    chk(bit_err && !arb_lost && !arb_won, "R6 bit error", bit_err, 1);
                    done = 1;
                end else if (i == last) begin
                    chk(arb_won && !arb_lost && !bit_err, "R5 won pulse", arb_won, 1);
                    chk(won_idx == IW'(best), "R5 won_idx", won_idx, best);
                    done = 1;
                end else begin
                    chk(!arb_won && !arb_lost && !bit_err, "R4 R5 R6 no flag mid-field",
                        {arb_won, arb_lost, bit_err}, 0);
                end
            end
            for (int i = 0; i < 3; i++) begin
                rx_bit = 1'($urandom); bit_tick = 1;
                step();
                chk(tx_bit && !arb_busy && !arb_won && !arb_lost && !bit_err,
                    "R4 R5 R6 recessive after field", tx_bit, 1);
            end
        end
        frame_end = 1;
        step();
        chk(tx_bit && !arb_busy, "R8 frame_end idle", tx_bit, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk(tx_bit && !arb_busy && !arb_won && !arb_lost && !bit_err, "R1 reset state", tx_bit, 1);
        rst_n = 1;
        step();
        chk(tx_bit && !arb_busy, "R1 after reset", tx_bit, 1);
        // directed: equal keys in two entries, lowest index chosen
        tx_valid = 4'b1010; tx_ext = '0; tx_rtr = '0;
        tx_id = '0; tx_id[1*29 +: 29] = 29'h123; tx_id[3*29 +: 29] = 29'h123;
        #1;
        chk(sel_idx == 2'd1, "R2 tie lowest index", sel_idx, 1);
        // directed: standard beats extended with same base when RTR=0
        tx_valid = 4'b0011; tx_ext = 4'b0001;
        tx_id[0 +: 29] = {11'h123, 18'h0}; tx_id[29 +: 29] = 29'h123;
        #1;
        chk(sel_idx == 2'd1, "R2 standard over extended", sel_idx, 1);
        run_frame(1);
        for (int f = 0; f < 250; f++) run_frame(f % 25 == 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule